// File: doc/BRIEF.md
# Serial audio frame engine

This block is a clock-master serial audio transmitter. It divides the system clock down to a bit clock, produces a frame sync and shifts out parallel sample words one bit per bit-clock period. Every property of the framing is a separate setting: sync polarity, whether sync leads the first data bit by one bit, whether sync lasts one bit or one whole word, bit-clock polarity, bit order, word length, one or two words per frame, and a mask that silences chosen slots. Combinations of these give the usual stereo framings. A low-level sync that is early and one word wide gives I2S. A high-level wide sync on the first bit gives left-justified. A high-level one-bit sync that is early gives DSP-A. The same sync on the first bit gives DSP-B.

Samples arrive through a valid/ready handshake, one word for each active slot at the moment that slot starts. Settings are loaded with a write strobe while the engine is disabled. Raising the enable starts a frame at slot 0, bit 0. Lowering it returns every line to its idle level.

Top module: `aud_frame_tx`

## Requirements
- R1: After reset, with en low: bclk is 0, fsync is 0, sdata is 0, underrun is 0, and s_ready stays 0 even when s_valid is 1.
- R2: While enabled, one bclk period is 2*(cfg_half+1) clk cycles. The sampling edge is a rising edge of (bclk XOR bclk_inv), where bclk_inv is the cfg_bclk_inv setting.
- R3: sdata and fsync change only on the launch edge, which is a falling edge of (bclk XOR bclk_inv). The one exception is the first bit after enable, which is set up before the first sampling edge.
- R4: A frame has (cfg_slots+1) slots of (cfg_wlen+1) bits each, and every slot uses the same length. The first sampling edge after enable carries slot 0, bit 0.
- R5: With cfg_lsb_first=0, bit cfg_wlen of a word is sent first and bit 0 last. With cfg_lsb_first=1 the order is reversed.
- R6: The sync level is 1 at frame position 0 when cfg_fs_wide=0, and at positions 0..cfg_wlen (all of slot 0) when cfg_fs_wide=1. With cfg_fs_early=1 this window moves one position earlier and wraps to the last bit of the frame. cfg_fs_low=1 inverts the level driven on fsync.
- R7: A sample is taken (s_valid and s_ready both 1 on a clk edge) exactly once at the start of each active slot. s_ready is never 1 for two cycles in a row.
- R8: A slot whose cfg_mask bit is 1 (bit s for slot s) sends 0 on every bit and takes no sample.
- R9: If s_valid is 0 when an active slot starts, the slot sends all zeros and underrun is 1 for exactly one clk cycle.
- R10: A configuration write is accepted only while en is low and the engine is idle. A write while running has no effect on the framing.
- R11: One cycle after en goes low, sdata is 0 and fsync sits at its inactive level (cfg_fs_low). Once clk has gone on to the next cycle, bclk sits at cfg_bclk_inv. The next enable restarts at slot 0, bit 0.
- R12: Bits of s_data above bit cfg_wlen are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; rising starts a frame |
| cfg_we | input | 1 | Configuration write strobe (accepted only when idle) |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_fs_low | input | 1 | Frame sync active low |
| cfg_fs_early | input | 1 | Sync leads the frame by one bit |
| cfg_fs_wide | input | 1 | Sync lasts one word instead of one bit |
| cfg_lsb_first | input | 1 | Send bit 0 first |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_slots | input | 1 | Slots per frame minus one |
| cfg_mask | input | 2 | Slot mask, 1 = slot silent |
| cfg_half | input | 8 | Bit-clock half period minus one, in clk cycles |
| s_valid | input | 1 | Sample available |
| s_data | input | 32 | Sample word |
| s_ready | output | 1 | Sample taken this cycle |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse for a missing sample |

## Verification
The assertions assume that reset is applied before the first enable. They also assume that the slot count never exceeds the slot parameter, and that the inputs settle between clock edges. The bench drives everything on the falling clk edge and holds reset over the first edges. It writes the configuration only while en is low, except in the one test that deliberately writes during a run. It lowers en in the same half cycle as the last expected sampling edge, so no slot beyond the captured frames can start.

// File: rtl/aft_pkg.sv
package aft_pkg;

  // framing flags, one bit each, grouped so they load together
  typedef struct packed {
    logic bclk_inv;
    logic fs_low;
    logic fs_early;
    logic fs_wide;
    logic lsb_first;
  } aft_flags_t;

  // bit clock half: data launched in LAUNCH, sampled at entry to SAMPLE
  typedef enum logic {
    PH_LAUNCH = 1'b0,
    PH_SAMPLE = 1'b1
  } aft_phase_e;

endpackage

// File: rtl/aft_cfg_regs.sv
module aft_cfg_regs
  import aft_pkg::*;
#(
  parameter int WLEN_W    = 5,
  parameter int SLOT_IW   = 1,
  parameter int MAX_SLOTS = 2,
  parameter int DIV_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 run,
  input  logic                 we,
  input  aft_flags_t           flags_in,
  input  logic [WLEN_W-1:0]    wlen_in,
  input  logic [SLOT_IW-1:0]   slots_in,
  input  logic [MAX_SLOTS-1:0] mask_in,
  input  logic [DIV_W-1:0]     half_in,
  output aft_flags_t           flags_q,
  output logic [WLEN_W-1:0]    wlen_q,
  output logic [SLOT_IW-1:0]   slots_q,
  output logic [MAX_SLOTS-1:0] mask_q,
  output logic [DIV_W-1:0]     half_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      wlen_q  <= '1;
      slots_q <= '1;
      mask_q  <= '0;
      half_q  <= '0;
    end else if (we && !en && !run) begin
      flags_q <= flags_in;
      wlen_q  <= wlen_in;
      slots_q <= slots_in;
      mask_q  <= mask_in;
      half_q  <= half_in;
    end
  end

  // R10: settings frozen while the engine runs
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable({flags_q, wlen_q, slots_q, mask_q, half_q}));

endmodule

// File: rtl/aft_bitclk.sv
module aft_bitclk
  import aft_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  input  logic             bclk_inv,
  output logic             run,
  output logic             start,
  output logic             launch,
  output logic             bclk
);

  logic [DIV_W-1:0] cnt;
  aft_phase_e       phase;

  assign start  = en && !run;
  assign launch = start || (en && run && (cnt == half) && (phase == PH_SAMPLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cnt   <= '0;
      phase <= PH_LAUNCH;
      bclk  <= 1'b0;
    end else if (!en) begin
      run   <= 1'b0;
      cnt   <= '0;
      phase <= PH_LAUNCH;
      bclk  <= bclk_inv;
    end else if (!run) begin
      run   <= 1'b1;
      cnt   <= '0;
      phase <= PH_LAUNCH;
      bclk  <= bclk_inv;
    end else if (cnt == half) begin
      cnt   <= '0;
      phase <= (phase == PH_LAUNCH) ? PH_SAMPLE : PH_LAUNCH;
      bclk  <= (phase == PH_LAUNCH) ^ bclk_inv;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/aft_sequencer.sv
module aft_sequencer #(
  parameter int WLEN_W    = 5,
  parameter int SLOT_IW   = 1,
  parameter int MAX_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 start,
  input  logic                 launch,
  input  logic [WLEN_W-1:0]    wlen,
  input  logic [SLOT_IW-1:0]   last_slot,
  input  logic [MAX_SLOTS-1:0] mask,
  input  logic                 fs_low,
  input  logic                 fs_early,
  input  logic                 fs_wide,
  input  logic                 s_valid,
  output logic [WLEN_W-1:0]    nbit,
  output logic                 slot_first,
  output logic                 active,
  output logic                 take,
  output logic                 fsync,
  output logic                 underrun
);

  logic [WLEN_W-1:0]  bit_q, eb, fb;
  logic [SLOT_IW-1:0] slot_q, ns, es, fsl;
  logic               fs_lvl;

  // position of the bit about to launch, and the one after it
  always_comb begin
    if (start) begin
      nbit = '0;
      ns   = '0;
    end else if (bit_q == wlen) begin
      nbit = '0;
      ns   = (slot_q == last_slot) ? '0 : SLOT_IW'(slot_q + 1'b1);
    end else begin
      nbit = WLEN_W'(bit_q + 1'b1);
      ns   = slot_q;
    end
    if (nbit == wlen) begin
      eb = '0;
      es = (ns == last_slot) ? '0 : SLOT_IW'(ns + 1'b1);
    end else begin
      eb = WLEN_W'(nbit + 1'b1);
      es = ns;
    end
    fb     = fs_early ? eb : nbit;
    fsl    = fs_early ? es : ns;
    fs_lvl = (fsl == '0) && (fs_wide || (fb == '0));
  end

  assign slot_first = launch && (nbit == '0);
  assign active     = !mask[ns];
  assign take       = slot_first && active && s_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q    <= '0;
      slot_q   <= '0;
      fsync    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= slot_first && active && !s_valid;
      if (!en) begin
        fsync <= fs_low;
      end else if (launch) begin
        bit_q  <= nbit;
        slot_q <= ns;
        fsync  <= fs_lvl ^ fs_low;
      end
    end
  end

  // R7: one handshake per slot start
  p_take_single_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

  // R9: underrun is a single-cycle pulse
  p_underrun_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);

endmodule

// File: rtl/aft_shifter.sv
module aft_shifter #(
  parameter int MAX_WORD = 32,
  parameter int WLEN_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                launch,
  input  logic                slot_first,
  input  logic                active,
  input  logic                take,
  input  logic [WLEN_W-1:0]   nbit,
  input  logic [WLEN_W-1:0]   wlen,
  input  logic                lsb_first,
  input  logic [MAX_WORD-1:0] s_data,
  output logic                sdata
);

  logic [MAX_WORD-1:0] word_q, new_word, cur;
  logic [WLEN_W-1:0]   idx;

  assign new_word = take ? s_data : '0;
  assign cur      = slot_first ? new_word : word_q;
  assign idx      = lsb_first ? nbit : WLEN_W'(wlen - nbit);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sdata  <= 1'b0;
    end else if (!en) begin
      sdata  <= 1'b0;
    end else if (launch) begin
      sdata <= cur[idx];
      if (slot_first) word_q <= new_word;
    end
  end

  // R8: a masked slot starts with a zero bit
  p_masked_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (slot_first && !active) |=> !sdata);

endmodule

// File: rtl/aud_frame_tx.sv
module aud_frame_tx
  import aft_pkg::*;
#(
  parameter int MAX_WORD  = 32,
  parameter int MAX_SLOTS = 2,
  parameter int DIV_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic                         cfg_we,
  input  logic                         cfg_bclk_inv,
  input  logic                         cfg_fs_low,
  input  logic                         cfg_fs_early,
  input  logic                         cfg_fs_wide,
  input  logic                         cfg_lsb_first,
  input  logic [$clog2(MAX_WORD)-1:0]  cfg_wlen,
  input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slots,
  input  logic [MAX_SLOTS-1:0]         cfg_mask,
  input  logic [DIV_W-1:0]             cfg_half,
  input  logic                         s_valid,
  input  logic [MAX_WORD-1:0]          s_data,
  output logic                         s_ready,
  output logic                         bclk,
  output logic                         fsync,
  output logic                         sdata,
  output logic                         underrun
);

  localparam int WLEN_W  = $clog2(MAX_WORD);
  localparam int SLOT_IW = $clog2(MAX_SLOTS);

  aft_flags_t           flags_in, flags_q;
  logic [WLEN_W-1:0]    wlen_q, nbit;
  logic [SLOT_IW-1:0]   slots_q;
  logic [MAX_SLOTS-1:0] mask_q;
  logic [DIV_W-1:0]     half_q;
  logic                 run, start, launch, slot_first, active, take;

  assign flags_in = '{bclk_inv:  cfg_bclk_inv,  fs_low:  cfg_fs_low,
                      fs_early:  cfg_fs_early,  fs_wide: cfg_fs_wide,
                      lsb_first: cfg_lsb_first};

  aft_cfg_regs #(.WLEN_W(WLEN_W), .SLOT_IW(SLOT_IW), .MAX_SLOTS(MAX_SLOTS), .DIV_W(DIV_W))
  u_cfg (
    .clk(clk), .rst(rst), .en(en), .run(run), .we(cfg_we),
    .flags_in(flags_in), .wlen_in(cfg_wlen), .slots_in(cfg_slots),
    .mask_in(cfg_mask), .half_in(cfg_half),
    .flags_q(flags_q), .wlen_q(wlen_q), .slots_q(slots_q),
    .mask_q(mask_q), .half_q(half_q)
  );

  aft_bitclk #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst(rst), .en(en), .half(half_q), .bclk_inv(flags_q.bclk_inv),
    .run(run), .start(start), .launch(launch), .bclk(bclk)
  );

  aft_sequencer #(.WLEN_W(WLEN_W), .SLOT_IW(SLOT_IW), .MAX_SLOTS(MAX_SLOTS)) u_seq (
    .clk(clk), .rst(rst), .en(en), .start(start), .launch(launch),
    .wlen(wlen_q), .last_slot(slots_q), .mask(mask_q),
    .fs_low(flags_q.fs_low), .fs_early(flags_q.fs_early), .fs_wide(flags_q.fs_wide),
    .s_valid(s_valid), .nbit(nbit), .slot_first(slot_first), .active(active),
    .take(take), .fsync(fsync), .underrun(underrun)
  );

  aft_shifter #(.MAX_WORD(MAX_WORD), .WLEN_W(WLEN_W)) u_shift (
    .clk(clk), .rst(rst), .en(en), .launch(launch), .slot_first(slot_first),
    .active(active), .take(take), .nbit(nbit), .wlen(wlen_q),
    .lsb_first(flags_q.lsb_first), .s_data(s_data), .sdata(sdata)
  );

  assign s_ready = take;

  logic bclk_lvl;
  assign bclk_lvl = bclk ^ flags_q.bclk_inv;

  // R3: line changes during a run coincide with the launch edge
  p_data_on_launch_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && run && !$stable({sdata, fsync})) |-> $fell(bclk_lvl));

  // R11: disabling quiets the data and underrun lines
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sdata && !underrun));

endmodule

// File: tb/test_aud_frame_tx.sv
module test_aud_frame_tx;

  typedef struct packed {
    logic       inv, low, early, wide, lsb;
    logic [4:0] wlen;
    logic       slots;
    logic [1:0] mask;
    logic [7:0] half;
    logic       feed;
  } vec_t;

  localparam int NV = 10;
  // inv low early wide lsb  wlen   slots mask   half  feed
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 5'd15, 1'b1, 2'b00, 8'd1, 1'b1},  // I2S
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 5'd15, 1'b1, 2'b00, 8'd0, 1'b1},  // left-justified
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 5'd7,  1'b1, 2'b00, 8'd2, 1'b1},  // DSP-A
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 5'd23, 1'b1, 2'b00, 8'd0, 1'b1},  // DSP-B
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 5'd11, 1'b0, 2'b00, 8'd1, 1'b1},  // mono, lsb, inv clk
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 5'd7,  1'b1, 2'b10, 8'd0, 1'b1},  // slot 1 masked
    '{1'b0,1'b0,1'b1,1'b0,1'b1, 5'd4,  1'b1, 2'b01, 8'd3, 1'b1},  // slot 0 masked
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 5'd31, 1'b1, 2'b00, 8'd0, 1'b1},  // full 32-bit words
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 5'd7,  1'b1, 2'b00, 8'd0, 1'b0},  // no samples
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 5'd7,  1'b1, 2'b01, 8'd1, 1'b0}   // no samples, masked
  };

  logic        clk = 1'b0;
  logic        rst, en, cfg_we;
  logic        cfg_bclk_inv, cfg_fs_low, cfg_fs_early, cfg_fs_wide, cfg_lsb_first;
  logic [4:0]  cfg_wlen;
  logic        cfg_slots;
  logic [1:0]  cfg_mask;
  logic [7:0]  cfg_half;
  logic        s_valid;
  logic [31:0] s_data;
  logic        s_ready, bclk, fsync, sdata, underrun;

  always #2 clk = ~clk;  // 250 MHz

  aud_frame_tx i_aud_frame_tx (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_fs_low(cfg_fs_low), .cfg_fs_early(cfg_fs_early),
    .cfg_fs_wide(cfg_fs_wide), .cfg_lsb_first(cfg_lsb_first), .cfg_wlen(cfg_wlen),
    .cfg_slots(cfg_slots), .cfg_mask(cfg_mask), .cfg_half(cfg_half),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .bclk(bclk), .fsync(fsync), .sdata(sdata), .underrun(underrun)
  );

  int n_chk = 0, n_fail = 0;
  int k = 0, ur_cnt = 0, ncap = 0, stop_at = 0, cyc = 0;
  bit feed_on = 0, cap_on = 0, cur_inv = 0, prev_lvl = 0, lvl;
  bit cap_d [256];
  bit cap_f [256];
  int stamp [2];

  function automatic logic [31:0] gen(input int a);
    return (32'h9E3779B9 * 32'(a + 1)) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sample feeder: drive on falling edge, note handshake before rising edge
  always @(negedge clk) begin
    s_valid = feed_on;
    s_data  = gen(k);
    #1;
    if (s_valid && s_ready) k++;
  end

  // capture on each sampling edge of the bit clock
  always @(negedge clk) begin
    cyc++;
    lvl = bclk ^ cur_inv;
    if (cap_on && lvl && !prev_lvl && ncap < 256) begin
      cap_d[ncap] = sdata;
      cap_f[ncap] = fsync;
      if (ncap < 2) stamp[ncap] = cyc;
      ncap++;
      if (ncap == stop_at) en = 1'b0;
    end
    prev_lvl = lvl;
    if (cap_on && underrun) ur_cnt++;
  end

  task automatic run_case(input vec_t c, input bit mid_wr, input string tag);
    int W, S, N, act, target, derr, ferr, iter, p, f, s, b, a, q;
    logic [31:0] w;
    bit ed, ef;
    W = int'(c.wlen) + 1;
    S = int'(c.slots) + 1;
    N = W * S;
    act = 0;
    for (int j = 0; j < S; j++) if (!c.mask[j]) act++;
    target = 2 * N;

    @(negedge clk);
    cfg_bclk_inv = c.inv; cfg_fs_low = c.low; cfg_fs_early = c.early;
    cfg_fs_wide = c.wide; cfg_lsb_first = c.lsb; cfg_wlen = c.wlen;
    cfg_slots = c.slots; cfg_mask = c.mask; cfg_half = c.half;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_inv = c.inv;
    repeat (3) @(negedge clk);
    k = 0; ur_cnt = 0; ncap = 0; stop_at = target;
    feed_on = c.feed; cap_on = 1'b1;
    @(negedge clk);
    en = 1'b1;
    iter = 0;
    while (ncap < target) begin
      @(negedge clk);
      iter++;
      if (mid_wr && iter == 12) begin
        // R10: write attempted while running
        cfg_bclk_inv = ~c.inv; cfg_fs_low = ~c.low; cfg_fs_early = ~c.early;
        cfg_fs_wide = ~c.wide; cfg_lsb_first = ~c.lsb; cfg_wlen = 5'd3;
        cfg_slots = 1'b0; cfg_mask = 2'b11; cfg_half = 8'd5;
        cfg_we = 1'b1;
      end else begin
        cfg_we = 1'b0;
      end
    end
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    cap_on = 1'b0;
    feed_on = 1'b0;

    derr = 0; ferr = 0;
    for (int i = 0; i < target; i++) begin
      p = i % N; f = i / N; s = p / W; b = p % W;
      if (c.mask[s]) ed = 1'b0;
      else begin
        a = f * act;
        for (int j = 0; j < s; j++) if (!c.mask[j]) a++;
        w = c.feed ? gen(a) : 32'd0;
        ed = c.lsb ? w[b] : w[W-1-b];
      end
      q = c.early ? (p + 1) % N : p;
      ef = (c.wide ? (q < W) : (q == 0)) ^ c.low;
      if (cap_d[i] != ed) derr++;
      if (cap_f[i] != ef) ferr++;
    end

    chk(derr == 0, "R4 R5 R8 R12", {tag, " data bit mismatches"}, derr, 0);
    chk(ferr == 0, "R6", {tag, " sync mismatches"}, ferr, 0);
    chk(k == (c.feed ? 2*act : 0), "R7 R8", {tag, " samples taken"}, k, c.feed ? 2*act : 0);
    chk(ur_cnt == (c.feed ? 0 : 2*act), "R9", {tag, " underrun pulses"}, ur_cnt, c.feed ? 0 : 2*act);
    chk(stamp[1] - stamp[0] == 2*(int'(c.half)+1), "R2", {tag, " bit period"},
        stamp[1] - stamp[0], 2*(int'(c.half)+1));
    chk(sdata == 1'b0 && fsync == c.low && bclk == c.inv && s_ready == 1'b0,
        "R11 R1", {tag, " idle levels {sdata,fsync,bclk}"},
        int'({sdata, fsync, bclk}), int'({1'b0, c.low, c.inv}));
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; cfg_we = 1'b0;
    cfg_bclk_inv = 0; cfg_fs_low = 0; cfg_fs_early = 0; cfg_fs_wide = 0; cfg_lsb_first = 0;
    cfg_wlen = 0; cfg_slots = 0; cfg_mask = 0; cfg_half = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    feed_on = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    // R1: reset state with a sample offered
    chk(bclk == 1'b0, "R1", "reset bclk", int'(bclk), 0);
    chk(fsync == 1'b0, "R1", "reset fsync", int'(fsync), 0);
    chk(sdata == 1'b0, "R1", "reset sdata", int'(sdata), 0);
    chk(underrun == 1'b0, "R1", "reset underrun", int'(underrun), 0);
    chk(s_ready == 1'b0, "R1", "s_ready while disabled", int'(s_ready), 0);
    feed_on = 1'b0;

    for (int v = 0; v < NV; v++) run_case(VECS[v], 1'b0, $sformatf("vec%0d", v));
    // R10: write during a run must not alter the left-justified framing
    run_case(VECS[1], 1'b1, "R10 run-time write");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule